// File: doc/BRIEF.md
# Debug power-control register with access trapping

This block holds the privileged "no powerdown" control bit of a processing element, together with the logic that decides whether each system-register access to it may go ahead. The stored bit drives an output to an external power controller. While that output is high, a powerdown request to the core domain must be emulated and must not switch the domain off. The power controller is not part of this block.

Each access arrives as a single-cycle request. The request carries its direction, a 64-bit write word and the current privilege level, from 0 to 3. Configuration inputs describe the following:
- whether the top privilege level is present;
- whether the hypervisor level is enabled;
- whether fine-grained traps exist, and the top level's enable for them;
- the halted state and the secure-debug-disable flag;
- the top-level trap bit and the two hypervisor trap bits;
- the read and write fine-grained trap bits.

One cycle after a request, the block returns one registered one-hot outcome: proceed, undefined, trap to level 2 or trap to level 3. With it come the read data and a syndrome class.

A cold reset gives the bit a value that depends on the powerup-request input. The bit can also be reloaded from that input when the core leaves a retention state.

Top module: `dbg_pwr_ctl`

## Requirements
- R1: The register is 64 bits wide and only bit 0 is stored. On a read that proceeds, `rsp_rdata` is 63 zero bits above the stored bit. Write data bits 63:1 are ignored. For any response other than a proceeding read, `rsp_rdata` is all zero.
- R2: `nopd_out` always equals the stored bit.
- R3: Any request at privilege level 0 (`req_el` = 0) gives the outcome undefined, whatever the configuration is.
- R4: At level 1 the checks apply in this order, and the first one that matches decides the outcome:
  - (a) Undefined, when halted, top level present, secure-debug-disable set, parameter `SDD_TRAP_FIRST` = 1 and the top-level trap bit set.
  - (b) Trap to level 2, when the hypervisor is enabled, fine-grained traps exist, the top level is absent or its fine-grained enable is set, and the fine-grained trap bit for this direction is set.
  - (c) Trap to level 2, when the hypervisor is enabled and either hypervisor trap bit is set.
  - (d) When the top level is present and its trap bit is set: undefined if halted with secure-debug-disable set, and trap to level 3 otherwise.
  - (e) Otherwise the access proceeds.
- R5: At level 2 only steps (a), (d) and (e) of R4 apply. At level 3 every access proceeds.
- R6: A read tests `cfg_fgt_rd_trap` and a write tests `cfg_fgt_wr_trap`. The other fine-grained bit has no effect on that access.
- R7: A trap to level 2 or level 3 reports `rsp_syndrome` = 0x18. Every other response reports 0.
- R8: A cold reset (`rst_n` low at a clock edge) loads the bit with 0 when `pwrup_req` is low, and with parameter `COLD_PWRUP_VAL` when `pwrup_req` is high. A cold reset also clears the response outputs.
- R9: With `RET_RELOAD` = 1, a cycle with `retention_exit` high loads the bit from `pwrup_req`. With `RET_RELOAD` = 0 the bit is kept. A write that proceeds in the same cycle takes precedence over the retention reload.
- R10: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high. When it is high, `rsp_outcome` is one-hot with bit 0 = proceed, bit 1 = undefined, bit 2 = trap to level 2 and bit 3 = trap to level 3. With no request, `rsp_outcome` is 0.
- R11: The bit takes write data bit 0 on the edge that accepts a write that proceeds. That update appears on `nopd_out` after that edge. A write that does not proceed leaves the bit unchanged, and the halted state never blocks a write that proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write word |
| req_el | input | 2 | Current privilege level |
| cfg_top_present | input | 1 | Top privilege level implemented |
| cfg_hyp_enabled | input | 1 | Hypervisor level enabled |
| cfg_fgt_present | input | 1 | Fine-grained traps implemented |
| cfg_top_fgt_en | input | 1 | Top-level enable for fine-grained traps |
| cfg_halted | input | 1 | Core is halted in debug |
| cfg_sdd | input | 1 | Secure-debug-disable flag |
| cfg_top_trap | input | 1 | Top-level trap bit for debug accesses |
| cfg_hyp_trap_a | input | 1 | First hypervisor trap bit |
| cfg_hyp_trap_b | input | 1 | Second hypervisor trap bit |
| cfg_fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| cfg_fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| pwrup_req | input | 1 | External powerup-request input |
| retention_exit | input | 1 | Pulse on leaving a retention state |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 4 | One-hot outcome |
| rsp_rdata | output | 64 | Read data |
| rsp_syndrome | output | 6 | Trap syndrome class |
| nopd_out | output | 1 | No-powerdown request to power controller |

## Verification
The bench sweeps every privilege level, both directions and all 2048 settings of the eleven trap controls. This exercises each priority step while every lower step is also active. A chain with two steps swapped would then report a trap to level 2 where undefined is due, or a trap to level 3 where a hypervisor trap is due. Each write in the sweep flips the requested bit and sets all upper write bits. A design that stored the data of a write that did not proceed, or that let the upper bits through, would show a wrong `nopd_out` or a wrong read word. Directed cases cover three further points:
- swapped fine-grained read and write bits;
- the cold-reset value for both levels of `pwrup_req`;
- a retention reload in the same cycle as a write that proceeds, where a design with the wrong order would drop the written value.

// File: rtl/dpc_pkg.sv
// Shared types for the debug power-control register.
// Assumes outcome codes are one-hot so that the response can be checked per bit.
package dpc_pkg;
    localparam int unsigned SYN_W = 6;
    localparam logic [SYN_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_OK    = 4'b0001,
        OUT_UNDEF = 4'b0010,
        OUT_TRAP2 = 4'b0100,
        OUT_TRAP3 = 4'b1000
    } outcome_e;

    typedef struct packed {
        logic top_present;
        logic hyp_enabled;
        logic fgt_present;
        logic top_fgt_en;
        logic halted;
        logic sdd;
        logic top_trap;
        logic hyp_trap_a;
        logic hyp_trap_b;
        logic fgt_rd;
        logic fgt_wr;
    } trap_cfg_t;
endpackage

// File: rtl/dpc_access_judge.sv
// Combinational legality check for one access to the power-control register.
// Evaluates the ordered trap chain for the given privilege level and direction.
// Assumes the configuration inputs are stable during the request cycle.
module dpc_access_judge
    import dpc_pkg::*;
#(
    parameter bit SDD_TRAP_FIRST = 1'b1
) (
    input  logic [1:0] el,
    input  logic       is_write,
    input  trap_cfg_t  cfg,
    output outcome_e   verdict
);
    logic     fgt_bit;
    logic     early_undef;
    logic     fgt_hit;
    logic     hyp_hit;
    logic     top_hit;
    outcome_e top_verdict;

    // Evaluate each step of the chain on its own.
    always_comb begin
        fgt_bit     = is_write ? cfg.fgt_wr : cfg.fgt_rd;
        early_undef = SDD_TRAP_FIRST & cfg.halted & cfg.top_present & cfg.sdd & cfg.top_trap;
        fgt_hit     = cfg.hyp_enabled & cfg.fgt_present &
                      (~cfg.top_present | cfg.top_fgt_en) & fgt_bit;
        hyp_hit     = cfg.hyp_enabled & (cfg.hyp_trap_a | cfg.hyp_trap_b);
        top_hit     = cfg.top_present & cfg.top_trap;
        top_verdict = (cfg.halted & cfg.sdd) ? OUT_UNDEF : OUT_TRAP3;
    end

    // Pick the first matching step for the current privilege level.
    always_comb begin
        unique case (el)
            2'd0: verdict = OUT_UNDEF;
            2'd1: begin
                if (early_undef)  verdict = OUT_UNDEF;
                else if (fgt_hit) verdict = OUT_TRAP2;
                else if (hyp_hit) verdict = OUT_TRAP2;
                else if (top_hit) verdict = top_verdict;
                else              verdict = OUT_OK;
            end
            2'd2: begin
                if (early_undef)  verdict = OUT_UNDEF;
                else if (top_hit) verdict = top_verdict;
                else              verdict = OUT_OK;
            end
            default: verdict = OUT_OK;
        endcase
    end
endmodule

// File: rtl/dpc_nopd_store.sv
// Storage for the power-control register word. Only the bits in the live mask
// are kept; the rest are held at zero. Handles cold reset, accepted writes and
// retention-exit reload, in that order of precedence.
// Assumes wr_en is asserted only for writes that the judge allowed.
module dpc_nopd_store #(
    parameter int unsigned DATA_W         = 64,
    parameter bit          COLD_PWRUP_VAL = 1'b1,
    parameter bit          RET_RELOAD     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrup_req,
    input  logic              retention_exit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] reg_word
);
    localparam logic [DATA_W-1:0] LIVE_MASK = {{(DATA_W-1){1'b0}}, 1'b1};

    logic              ret_load;
    logic [DATA_W-1:0] cold_word;
    logic [DATA_W-1:0] ret_word;

    // Select the retention-exit variant.
    generate
        if (RET_RELOAD) begin : g_reload
            assign ret_load = retention_exit;
        end else begin : g_keep
            assign ret_load = 1'b0 & retention_exit;
        end
    endgenerate

    // Compute the cold-reset and retention reload words.
    always_comb begin
        cold_word = {{(DATA_W-1){1'b0}}, pwrup_req & COLD_PWRUP_VAL};
        ret_word  = {{(DATA_W-1){1'b0}}, pwrup_req};
    end

    // Update the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_word <= cold_word;
        else if (wr_en)    reg_word <= wr_data & LIVE_MASK;
        else if (ret_load) reg_word <= ret_word;
    end
endmodule

// File: rtl/dpc_resp_reg.sv
// Registers the access outcome, read data and syndrome one cycle after a request.
// Assumes verdict and reg_word are the values of the request cycle.
module dpc_resp_reg
    import dpc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  outcome_e          verdict,
    input  logic [DATA_W-1:0] reg_word,
    output logic              rsp_valid,
    output logic [3:0]        rsp_outcome,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [SYN_W-1:0]  rsp_syndrome
);
    logic is_trap;
    logic rd_ok;

    // Classify the current verdict.
    always_comb begin
        is_trap = (verdict == OUT_TRAP2) || (verdict == OUT_TRAP3);
        rd_ok   = req_valid && !req_write && (verdict == OUT_OK);
    end

    // Capture the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_outcome  <= OUT_NONE;
            rsp_rdata    <= '0;
            rsp_syndrome <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_outcome  <= req_valid ? verdict : OUT_NONE;
            rsp_rdata    <= rd_ok ? reg_word : '0;
            rsp_syndrome <= (req_valid && is_trap) ? TRAP_CLASS : '0;
        end
    end
endmodule

// File: rtl/dbg_pwr_ctl.sv
// Debug power-control register: one stored no-powerdown bit with an ordered
// trap chain that decides whether each read or write proceeds.
// Assumes single-cycle requests and a synchronous active-low cold reset.
module dbg_pwr_ctl
    import dpc_pkg::*;
#(
    parameter int unsigned DATA_W         = 64,
    parameter bit          SDD_TRAP_FIRST = 1'b1,
    parameter bit          COLD_PWRUP_VAL = 1'b1,
    parameter bit          RET_RELOAD     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_el,
    input  logic              cfg_top_present,
    input  logic              cfg_hyp_enabled,
    input  logic              cfg_fgt_present,
    input  logic              cfg_top_fgt_en,
    input  logic              cfg_halted,
    input  logic              cfg_sdd,
    input  logic              cfg_top_trap,
    input  logic              cfg_hyp_trap_a,
    input  logic              cfg_hyp_trap_b,
    input  logic              cfg_fgt_rd_trap,
    input  logic              cfg_fgt_wr_trap,
    input  logic              pwrup_req,
    input  logic              retention_exit,
    output logic              rsp_valid,
    output logic [3:0]        rsp_outcome,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [5:0]        rsp_syndrome,
    output logic              nopd_out
);
    trap_cfg_t         cfg;
    outcome_e          verdict;
    logic              wr_en;
    logic [DATA_W-1:0] reg_word;

    // Gather the configuration inputs.
    always_comb begin
        cfg.top_present = cfg_top_present;
        cfg.hyp_enabled = cfg_hyp_enabled;
        cfg.fgt_present = cfg_fgt_present;
        cfg.top_fgt_en  = cfg_top_fgt_en;
        cfg.halted      = cfg_halted;
        cfg.sdd         = cfg_sdd;
        cfg.top_trap    = cfg_top_trap;
        cfg.hyp_trap_a  = cfg_hyp_trap_a;
        cfg.hyp_trap_b  = cfg_hyp_trap_b;
        cfg.fgt_rd      = cfg_fgt_rd_trap;
        cfg.fgt_wr      = cfg_fgt_wr_trap;
    end

    dpc_access_judge #(.SDD_TRAP_FIRST(SDD_TRAP_FIRST)) u_judge (
        .el       (req_el),
        .is_write (req_write),
        .cfg      (cfg),
        .verdict  (verdict)
    );

    // Only an allowed write touches the stored word.
    assign wr_en = req_valid && req_write && (verdict == OUT_OK);

    dpc_nopd_store #(
        .DATA_W         (DATA_W),
        .COLD_PWRUP_VAL (COLD_PWRUP_VAL),
        .RET_RELOAD     (RET_RELOAD)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwrup_req      (pwrup_req),
        .retention_exit (retention_exit),
        .wr_en          (wr_en),
        .wr_data        (req_wdata),
        .reg_word       (reg_word)
    );

    dpc_resp_reg #(.DATA_W(DATA_W)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .verdict      (verdict),
        .reg_word     (reg_word),
        .rsp_valid    (rsp_valid),
        .rsp_outcome  (rsp_outcome),
        .rsp_rdata    (rsp_rdata),
        .rsp_syndrome (rsp_syndrome)
    );

    assign nopd_out = reg_word[0];
endmodule

// File: rtl/dbg_pwr_ctl_chk.sv
// Checker for the debug power-control register, attached by bind.
// Assumes the same parameters as the instance it is bound to.
module dbg_pwr_ctl_chk #(
    parameter int unsigned DATA_W     = 64,
    parameter bit          RET_RELOAD = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_el,
    input logic              pwrup_req,
    input logic              retention_exit,
    input logic              rsp_valid,
    input logic [3:0]        rsp_outcome,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [5:0]        rsp_syndrome,
    input logic              nopd_out
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && rsp_outcome == 4'b0000);
    // R10
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_outcome) == 1);
    // R3
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_el == 2'd0 |=> rsp_outcome == 4'b0010);
    // R5
    el3_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_el == 2'd3 |=> rsp_outcome == 4'b0001);
    // R7
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_outcome[2] || rsp_outcome[3]) |-> rsp_syndrome == 6'h18);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[DATA_W-1:1] == '0);
    // R11
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) && !retention_exit |=> $stable(nopd_out));
    // R9
    ret_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        RET_RELOAD && retention_exit && !(req_valid && req_write) |=> nopd_out == $past(pwrup_req));
endmodule

bind dbg_pwr_ctl dbg_pwr_ctl_chk #(.DATA_W(DATA_W), .RET_RELOAD(RET_RELOAD)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_el         (req_el),
    .pwrup_req      (pwrup_req),
    .retention_exit (retention_exit),
    .rsp_valid      (rsp_valid),
    .rsp_outcome    (rsp_outcome),
    .rsp_rdata      (rsp_rdata),
    .rsp_syndrome   (rsp_syndrome),
    .nopd_out       (nopd_out)
);

// File: tb/dbg_pwr_ctl_test.sv
// Self-checking bench: sweeps every level, direction and trap setting, then
// runs directed reset, retention and fine-grained direction cases.
module dbg_pwr_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 64;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [DW-1:0] req_wdata;
    logic [1:0]    req_el;
    logic [10:0]   c;
    logic          pwrup_req, retention_exit;
    logic          rsp_valid;
    logic [3:0]    rsp_outcome;
    logic [DW-1:0] rsp_rdata;
    logic [5:0]    rsp_syndrome;
    logic          nopd_out;

    int   checks = 0;
    int   fails  = 0;
    logic exp_bit;
    logic [3:0]    exp_o;
    logic [DW-1:0] exp_rd;
    logic [5:0]    exp_syn;
    string         tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_pwr_ctl #(.DATA_W(DW), .SDD_TRAP_FIRST(1'b1), .COLD_PWRUP_VAL(1'b1), .RET_RELOAD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .req_el(req_el),
        .cfg_top_present(c[0]), .cfg_hyp_enabled(c[1]), .cfg_fgt_present(c[2]),
        .cfg_top_fgt_en(c[3]), .cfg_halted(c[4]), .cfg_sdd(c[5]), .cfg_top_trap(c[6]),
        .cfg_hyp_trap_a(c[7]), .cfg_hyp_trap_b(c[8]), .cfg_fgt_rd_trap(c[9]),
        .cfg_fgt_wr_trap(c[10]), .pwrup_req(pwrup_req), .retention_exit(retention_exit),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_rdata(rsp_rdata),
        .rsp_syndrome(rsp_syndrome), .nopd_out(nopd_out)
    );

    // Expected outcome from the requirement text (R3, R4, R5, R6).
    function automatic logic [3:0] model(input logic [1:0] el, input logic wr, input logic [10:0] k);
        logic fb;
        fb = wr ? k[10] : k[9];
        if (el == 2'd0) return 4'b0010;
        if (el == 2'd3) return 4'b0001;
        if (k[4] && k[0] && k[5] && k[6]) return 4'b0010;
        if (el == 2'd1) begin
            if (k[1] && k[2] && (!k[0] || k[3]) && fb) return 4'b0100;
            if (k[1] && (k[7] || k[8])) return 4'b0100;
        end
        if (k[0] && k[6]) return (k[4] && k[5]) ? 4'b0010 : 4'b1000;
        return 4'b0001;
    endfunction

    task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_el = 2'd0;
        req_wdata = '0; retention_exit = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; c = '0; pwrup_req = 1'b1;
        idle();
        cycle();
        // R8: cold reset with powerup request high loads COLD_PWRUP_VAL = 1
        chk("R8 cold reset pwrup=1", {63'b0, nopd_out}, 64'd1);
        chk("R10 reset rsp_valid", {63'b0, rsp_valid}, 64'd0);
        chk("R2 nopd matches bit", {63'b0, nopd_out}, 64'd1);
        pwrup_req = 1'b0;
        cycle();
        chk("R8 cold reset pwrup=0", {63'b0, nopd_out}, 64'd0);
        rst_n = 1'b1;
        exp_bit = 1'b0;
        cycle();
        chk("R10 idle no response", {59'b0, rsp_valid, rsp_outcome}, 64'd0);

        // Exhaustive sweep over level, direction and all trap controls.
        for (int i = 0; i < 16384; i++) begin
            req_el    = i[1:0];
            req_write = i[2];
            c         = i[13:3];
            req_valid = 1'b1;
            req_wdata = {{(DW-1){1'b1}}, ~exp_bit};
            exp_o   = model(req_el, req_write, c);
            exp_rd  = (!req_write && exp_o == 4'b0001) ? {63'b0, exp_bit} : 64'd0;
            exp_syn = (exp_o[2] || exp_o[3]) ? 6'h18 : 6'h00;
            if (exp_o == 4'b0001 && req_write) exp_bit = ~exp_bit;
            case (req_el)
                2'd0:    tag = "R3 level0 outcome";
                2'd1:    tag = "R4 R6 level1 outcome";
                default: tag = "R5 level2/3 outcome";
            endcase
            cycle();
            chk(tag, {60'b0, rsp_outcome}, {60'b0, exp_o});
            chk("R7 syndrome", {58'b0, rsp_syndrome}, {58'b0, exp_syn});
            chk("R1 read data", rsp_rdata, exp_rd);
            chk("R11 R2 stored bit", {63'b0, nopd_out}, {63'b0, exp_bit});
        end
        idle();
        c = '0;
        cycle();
        chk("R10 rsp drops after requests", {63'b0, rsp_valid}, 64'd0);

        // R6: read trapped by read bit, write not trapped by it (top absent, hyp en, fgt present).
        c = 11'b0; c[1] = 1'b1; c[2] = 1'b1; c[9] = 1'b1;
        req_valid = 1'b1; req_el = 2'd1; req_write = 1'b0;
        cycle();
        chk("R6 read uses read trap bit", {60'b0, rsp_outcome}, 64'b0100);
        req_write = 1'b1; req_wdata = {{(DW-1){1'b0}}, ~exp_bit};
        exp_bit = ~exp_bit;
        cycle();
        chk("R6 write ignores read trap bit", {60'b0, rsp_outcome}, 64'b0001);
        chk("R11 write while halted-free applied", {63'b0, nopd_out}, {63'b0, exp_bit});

        // R9: retention exit reloads from powerup request.
        idle(); c = '0;
        pwrup_req = 1'b1; retention_exit = 1'b1;
        cycle();
        chk("R9 retention reload to 1", {63'b0, nopd_out}, 64'd1);
        pwrup_req = 1'b0;
        cycle();
        chk("R9 retention reload to 0", {63'b0, nopd_out}, 64'd0);
        // R9: accepted write wins over simultaneous reload.
        req_valid = 1'b1; req_write = 1'b1; req_el = 2'd3; req_wdata = 64'd1;
        cycle();
        chk("R9 write beats retention reload", {63'b0, nopd_out}, 64'd1);
        // R11: rejected write (level 0) leaves the bit alone.
        idle(); req_valid = 1'b1; req_write = 1'b1; req_el = 2'd0; req_wdata = 64'd0;
        cycle();
        chk("R11 rejected write keeps bit", {63'b0, nopd_out}, 64'd1);
        // R11: halted core still accepts a write at level 3.
        c[4] = 1'b1; c[5] = 1'b1; req_el = 2'd3;
        cycle();
        chk("R11 halted write proceeds", {63'b0, nopd_out}, 64'd0);
        // R1: read at level 3 returns only bit 0.
        idle(); req_valid = 1'b1; req_el = 2'd3; c = '0;
        cycle();
        chk("R1 read after write", rsp_rdata, 64'd0);
        idle();
        cycle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule